// File: doc/BRIEF.md
# Device Register Window Decoder

This block sits behind a memory-mapped register window and splits it into four subregions: a capabilities array, a device status area, a mailbox area and a memory-device status area. Each request carries an address, a size code and write data on a 64-bit little-endian bus. The decoder checks the size and alignment of every access. It answers reads to the capability headers and to the fixed status values itself. It drops writes to the read-only areas without reporting an error. It passes mailbox accesses on to a sub-port in the same cycle as the request.

Every request gets a response exactly one cycle later. The response holds the read data, placed on its byte lanes, with all other lanes zero. A faulting access sets an error flag, returns zero and has no side effect. The base offsets and lengths of the subregions are parameters, and the window size is their span rounded up to a power of two.

Top module: `regwin_decoder`

## Requirements
- R1: `req_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. An access whose address is not a multiple of its size is a fault: the response has `rsp_err`=1 and `rsp_rdata`=0, and nothing is forwarded.
- R2: The first `MB_NARROW` bytes of the mailbox area hold 32-bit registers. An 8-byte access there is a fault, while 1, 2 and 4-byte accesses there are legal.
- R3: `rsp_valid` is high in the cycle after each cycle in which `req_valid` is high, and low otherwise.
- R4: The capabilities header qword sits at window offset 0. It holds ID 0 in bits [15:0], version 1 in bits [23:16] and a capability count of 3 in bits [47:32]. All other bits are zero.
- R5: Capability entry k (k = 1..3) sits at offset 0x10*k. Its first qword holds the ID in [15:0], version 1 in [23:16] and the base offset of the subregion in [63:32]. Its second qword holds the length of the subregion. The entries are device status (ID 0x0001), mailbox (ID 0x0002) and memory device (ID 0x4000), in that order. Any other qword of the capabilities area reads zero.
- R6: Every read of the device status area returns zero with no error.
- R7: The qword at offset 0 of the memory-device area reads 0x6: the mailbox-ready bit is bit 1 = 1, the media-status field is bits [3:2] = 01, and all other bits are zero. Other qwords of that area read zero.
- R8: Writes to the capabilities, device status and memory-device areas have no effect and no error. Later reads return unchanged values, and the mailbox port stays idle.
- R9: A legal mailbox access raises `mb_valid` in the same cycle. It also drives `mb_write`, `mb_size`, `req_wdata` on `mb_wdata`, and the offset inside the mailbox area on `mb_addr`. The read response is `mb_rdata` masked to the accessed lanes.
- R10: Byte enables and read data are little-endian on the lanes. The byte at address A uses lane A mod 8. `mb_be` has exactly 2^size bits set, starting at lane A mod 8, and lanes outside the access read zero.
- R11: An address outside all four subregions reads zero with no error, and a write there is dropped.
- R12: While reset is high, and in the first cycle after it, `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address within the window |
| req_size | input | 2 | Size code, bytes = 2^code |
| req_wdata | input | 64 | Lane-aligned write data |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Access was misaligned or had an illegal size |
| rsp_rdata | output | 64 | Lane-aligned read data, zero outside the access |
| mb_valid | output | 1 | Mailbox access forwarded this cycle |
| mb_write | output | 1 | Forwarded access is a write |
| mb_addr | output | ADDR_W | Offset inside the mailbox area |
| mb_size | output | 2 | Forwarded size code |
| mb_be | output | 8 | Forwarded byte enables |
| mb_wdata | output | 64 | Forwarded write data |
| mb_rdata | input | 64 | Mailbox read data, valid while mb_valid is high |

## Verification
Fault detection and mailbox forwarding are both decided in the request cycle, so the bench targets the cases where they collide. It sends 8-byte accesses into the narrow mailbox registers and misaligned quadword writes into the wide mailbox space. It then checks that `mb_valid` stays low in that same cycle and that the error response follows one cycle later. Legal mailbox reads next to these faulting ones confirm that forwarding itself still works and that the returned data is masked to the accessed lanes.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

    localparam int BUS_BYTES = 8;
    localparam int BUS_W     = 8 * BUS_BYTES;

    typedef enum logic [2:0] {
        RG_CAPS   = 3'd0,
        RG_DEVST  = 3'd1,
        RG_MBOX   = 3'd2,
        RG_MEMDEV = 3'd3,
        RG_HOLE   = 3'd4
    } region_e;

    typedef struct packed {
        region_e        region;
        logic           fault;
        logic [7:0]     lanes;
    } decode_t;

    localparam logic [15:0] HDR_ID      = 16'h0000;
    localparam logic [7:0]  CAP_VER     = 8'h01;
    localparam logic [15:0] CAP_COUNT   = 16'd3;
    localparam logic [15:0] ID_DEVST    = 16'h0001;
    localparam logic [15:0] ID_MBOX     = 16'h0002;
    localparam logic [15:0] ID_MEMDEV   = 16'h4000;

    // memory-device status word: ready flag bit 1, media field bits [3:2]
    localparam int          MD_READY_BIT = 1;
    localparam int          MD_MEDIA_LSB = 2;
    localparam logic [1:0]  MD_MEDIA_OK  = 2'b01;

    function automatic logic [7:0] lane_mask(input logic [1:0] size, input logic [2:0] low);
        logic [8:0] span;
        span = (9'd1 << (4'd1 << size)) - 9'd1;
        return span[7:0] << low;
    endfunction

    function automatic logic is_misaligned(input logic [1:0] size, input logic [2:0] low);
        return ({1'b0, low} & ((4'd1 << size) - 4'd1)) != 4'd0;
    endfunction

    function automatic logic [BUS_W-1:0] lanes_to_bits(input logic [7:0] be);
        logic [BUS_W-1:0] m;
        for (int i = 0; i < BUS_BYTES; i++) m[8*i +: 8] = {8{be[i]}};
        return m;
    endfunction

endpackage

// File: rtl/regwin_decode.sv
module regwin_decode
    import regwin_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int CAP_LEN   = 'h100,
    parameter int DEV_OFF   = 'h100,
    parameter int DEV_LEN   = 'h100,
    parameter int MB_OFF    = 'h400,
    parameter int MB_LEN    = 'h400,
    parameter int MD_OFF    = 'h800,
    parameter int MD_LEN    = 'h100,
    parameter int MB_NARROW = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        size,
    output decode_t           dec,
    output logic [ADDR_W-1:0] sub_off
);
    int   ai;
    int   base;
    logic narrow;

    always_comb begin
        ai   = int'(addr);
        base = 0;
        dec.region = RG_HOLE;
        if (ai < CAP_LEN) begin
            dec.region = RG_CAPS;
        end else if (ai >= DEV_OFF && ai < DEV_OFF + DEV_LEN) begin
            dec.region = RG_DEVST;
            base = DEV_OFF;
        end else if (ai >= MB_OFF && ai < MB_OFF + MB_LEN) begin
            dec.region = RG_MBOX;
            base = MB_OFF;
        end else if (ai >= MD_OFF && ai < MD_OFF + MD_LEN) begin
            dec.region = RG_MEMDEV;
            base = MD_OFF;
        end
        sub_off   = ADDR_W'(ai - base);
        narrow    = (dec.region == RG_MBOX) && (ai - MB_OFF < MB_NARROW);
        dec.fault = is_misaligned(size, addr[2:0]) || (narrow && size == 2'd3);
        dec.lanes = lane_mask(size, addr[2:0]);
    end
endmodule

// File: rtl/regwin_rom.sv
module regwin_rom
    import regwin_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DEV_OFF = 'h100,
    parameter int DEV_LEN = 'h100,
    parameter int MB_OFF  = 'h400,
    parameter int MB_LEN  = 'h400,
    parameter int MD_OFF  = 'h800,
    parameter int MD_LEN  = 'h100
) (
    input  region_e           region,
    input  logic [ADDR_W-4:0] word,
    output logic [BUS_W-1:0]  rdata
);
    localparam int N_CAPS = 3;
    localparam logic [15:0] ENT_ID  [N_CAPS] = '{ID_DEVST, ID_MBOX, ID_MEMDEV};
    localparam int          ENT_OFF [N_CAPS] = '{DEV_OFF, MB_OFF, MD_OFF};
    localparam int          ENT_LEN [N_CAPS] = '{DEV_LEN, MB_LEN, MD_LEN};

    localparam logic [BUS_W-1:0] HEADER =
        {16'h0, CAP_COUNT, 8'h0, CAP_VER, HDR_ID};
    localparam logic [BUS_W-1:0] MD_STATUS =
        (BUS_W'(MD_MEDIA_OK) << MD_MEDIA_LSB) | (BUS_W'(1) << MD_READY_BIT);

    logic [BUS_W-1:0] ent_lo [N_CAPS];
    logic [BUS_W-1:0] ent_hi [N_CAPS];

    for (genvar k = 0; k < N_CAPS; k++) begin : g_ent
        assign ent_lo[k] = {32'(ENT_OFF[k]), 8'h0, CAP_VER, ENT_ID[k]};
        assign ent_hi[k] = BUS_W'(ENT_LEN[k]);
    end

    always_comb begin
        rdata = '0;
        unique case (region)
            RG_CAPS: begin
                if (word == '0) rdata = HEADER;
                for (int k = 0; k < N_CAPS; k++) begin
                    if (int'(word) == 2*k + 2) rdata = ent_lo[k];
                    if (int'(word) == 2*k + 3) rdata = ent_hi[k];
                end
            end
            RG_MEMDEV: if (word == '0) rdata = MD_STATUS;
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/regwin_decoder.sv
module regwin_decoder
    import regwin_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int CAP_LEN   = 'h100,
    parameter int DEV_OFF   = 'h100,
    parameter int DEV_LEN   = 'h100,
    parameter int MB_OFF    = 'h400,
    parameter int MB_LEN    = 'h400,
    parameter int MD_OFF    = 'h800,
    parameter int MD_LEN    = 'h100,
    parameter int MB_NARROW = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    input  logic [63:0]       req_wdata,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata,
    output logic              mb_valid,
    output logic              mb_write,
    output logic [ADDR_W-1:0] mb_addr,
    output logic [1:0]        mb_size,
    output logic [7:0]        mb_be,
    output logic [63:0]       mb_wdata,
    input  logic [63:0]       mb_rdata
);
    localparam int SPAN     = MD_OFF + MD_LEN;
    localparam int WIN_SIZE = 1 << $clog2(SPAN);

    decode_t           dec;
    logic [ADDR_W-1:0] sub_off;
    logic [BUS_W-1:0]  rom_data;
    logic [BUS_W-1:0]  sel_data;

    regwin_decode #(
        .ADDR_W(ADDR_W), .CAP_LEN(CAP_LEN), .DEV_OFF(DEV_OFF), .DEV_LEN(DEV_LEN),
        .MB_OFF(MB_OFF), .MB_LEN(MB_LEN), .MD_OFF(MD_OFF), .MD_LEN(MD_LEN),
        .MB_NARROW(MB_NARROW)
    ) u_dec (
        .addr   (req_addr),
        .size   (req_size),
        .dec    (dec),
        .sub_off(sub_off)
    );

    regwin_rom #(
        .ADDR_W(ADDR_W), .DEV_OFF(DEV_OFF), .DEV_LEN(DEV_LEN),
        .MB_OFF(MB_OFF), .MB_LEN(MB_LEN), .MD_OFF(MD_OFF), .MD_LEN(MD_LEN)
    ) u_rom (
        .region(dec.region),
        .word  (sub_off[ADDR_W-1:3]),
        .rdata (rom_data)
    );

    initial begin
        if (WIN_SIZE > (1 << ADDR_W)) $error("window of %0d bytes exceeds address width", WIN_SIZE);
    end

    assign mb_valid = req_valid && !dec.fault && (dec.region == RG_MBOX);
    assign mb_write = req_write;
    assign mb_addr  = sub_off;
    assign mb_size  = req_size;
    assign mb_be    = dec.lanes;
    assign mb_wdata = req_wdata;

    always_comb begin
        sel_data = (dec.region == RG_MBOX) ? mb_rdata : rom_data;
        sel_data = sel_data & lanes_to_bits(dec.lanes);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_valid && dec.fault;
            rsp_rdata <= (req_valid && !dec.fault && !req_write) ? sel_data : '0;
        end
    end
endmodule

// File: rtl/regwin_decoder_chk.sv
module regwin_decoder_chk #(
    parameter int ADDR_W    = 12,
    parameter int MB_OFF    = 'h400,
    parameter int MB_NARROW = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              rsp_valid,
    input logic              rsp_err,
    input logic [63:0]       rsp_rdata,
    input logic              mb_valid,
    input logic [1:0]        mb_size,
    input logic [7:0]        mb_be
);
    logic misal;
    logic narrow_q;
    assign misal    = (int'(req_addr) % (1 << req_size)) != 0;
    assign narrow_q = (int'(req_addr) >= MB_OFF) && (int'(req_addr) < MB_OFF + MB_NARROW)
                      && (req_size == 2'd3);

    p_misal_no_fwd_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid && misal |-> !mb_valid);
    p_misal_err_r1: assert property (@(posedge clk) disable iff (rst)
        req_valid && misal |=> rsp_err);
    p_err_zero_r1: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_rdata == 64'd0);
    p_narrow_err_r2: assert property (@(posedge clk) disable iff (rst)
        req_valid && narrow_q |=> rsp_err);
    p_rsp_follows_r3: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);
    p_rsp_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);
    p_fwd_needs_req_r9: assert property (@(posedge clk) disable iff (rst)
        mb_valid |-> req_valid);
    p_be_count_r10: assert property (@(posedge clk) disable iff (rst)
        mb_valid |-> $countones(mb_be) == (1 << mb_size));
    p_reset_quiet_r12: assert property (@(posedge clk)
        rst |=> !rsp_valid);
endmodule

bind regwin_decoder regwin_decoder_chk #(
    .ADDR_W(ADDR_W), .MB_OFF(MB_OFF), .MB_NARROW(MB_NARROW)
) u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
    .rsp_rdata(rsp_rdata), .mb_valid(mb_valid), .mb_size(mb_size), .mb_be(mb_be)
);

// File: tb/regwin_decoder_tb.sv
`timescale 1ns/1ps
module regwin_decoder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [1:0]  req_size = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid, rsp_err;
    logic [63:0] rsp_rdata;
    logic        mb_valid, mb_write;
    logic [11:0] mb_addr;
    logic [1:0]  mb_size;
    logic [7:0]  mb_be;
    logic [63:0] mb_wdata;
    logic [63:0] mb_rdata = 64'h8877_6655_4433_2211;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    regwin_decoder u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .mb_valid(mb_valid), .mb_write(mb_write), .mb_addr(mb_addr),
        .mb_size(mb_size), .mb_be(mb_be), .mb_wdata(mb_wdata), .mb_rdata(mb_rdata)
    );

    // {addr, size, expected data, expected error}
    localparam int NV = 18;
    localparam logic [78:0] VEC [NV] = '{
        {12'h000, 2'd3, 64'h0000_0003_0001_0000, 1'b0}, // R4 header
        {12'h004, 2'd2, 64'h0000_0003_0000_0000, 1'b0}, // R4 count, R10 upper lanes
        {12'h006, 2'd1, 64'h0000_0000_0000_0000, 1'b0}, // R4 zero bits
        {12'h010, 2'd3, 64'h0000_0100_0001_0001, 1'b0}, // R5 entry 1
        {12'h022, 2'd1, 64'h0000_0000_0001_0000, 1'b0}, // R5 entry 2 version, R10
        {12'h029, 2'd0, 64'h0000_0000_0000_0400, 1'b0}, // R5 entry 2 length byte
        {12'h030, 2'd3, 64'h0000_0800_0001_4000, 1'b0}, // R5 entry 3
        {12'h038, 2'd2, 64'h0000_0000_0000_0100, 1'b0}, // R5 entry 3 length
        {12'h040, 2'd3, 64'h0000_0000_0000_0000, 1'b0}, // R5 past entries
        {12'h100, 2'd3, 64'h0000_0000_0000_0000, 1'b0}, // R6
        {12'h1F8, 2'd3, 64'h0000_0000_0000_0000, 1'b0}, // R6
        {12'h800, 2'd3, 64'h0000_0000_0000_0006, 1'b0}, // R7
        {12'h800, 2'd0, 64'h0000_0000_0000_0006, 1'b0}, // R7 byte
        {12'h801, 2'd0, 64'h0000_0000_0000_0000, 1'b0}, // R7 lane 1, R10
        {12'h003, 2'd1, 64'h0000_0000_0000_0000, 1'b1}, // R1 misaligned half
        {12'h004, 2'd3, 64'h0000_0000_0000_0000, 1'b1}, // R1 misaligned quad
        {12'h802, 2'd2, 64'h0000_0000_0000_0000, 1'b1}, // R1 misaligned word
        {12'h900, 2'd3, 64'h0000_0000_0000_0000, 1'b0}  // R11 hole
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, capture forward outputs, response sampled next negedge
    logic        f_valid, f_write;
    logic [11:0] f_addr;
    logic [7:0]  f_be;
    logic [63:0] f_wdata;

    task automatic access(input logic wr, input logic [11:0] a, input logic [1:0] s,
                          input logic [63:0] wd);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_size = s; req_wdata = wd;
        #1;
        f_valid = mb_valid; f_write = mb_write; f_addr = mb_addr;
        f_be = mb_be; f_wdata = mb_wdata;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R12 rsp_valid in reset", {63'd0, rsp_valid}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R12 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            access(1'b0, VEC[i][78:67], VEC[i][66:65], 64'd0);
            check("R3 rsp_valid", {63'd0, rsp_valid}, 64'd1);
            check($sformatf("R1/R4-R11 data @%h", VEC[i][78:67]), rsp_rdata, VEC[i][64:1]);
            check($sformatf("R1 err @%h", VEC[i][78:67]), {63'd0, rsp_err}, {63'd0, VEC[i][0]});
            check("R9 no forward outside mailbox", {63'd0, f_valid}, 64'd0);
        end
        @(negedge clk);
        check("R3 idle after request", {63'd0, rsp_valid}, 64'd0);

        // mailbox forwarding
        access(1'b0, 12'h408, 2'd3, 64'd0);
        check("R9 mb_valid", {63'd0, f_valid}, 64'd1);
        check("R9 mb_addr", {52'd0, f_addr}, 64'h8);
        check("R10 mb_be quad", {56'd0, f_be}, 64'hFF);
        check("R9 read data", rsp_rdata, 64'h8877_6655_4433_2211);
        access(1'b0, 12'h402, 2'd1, 64'd0);
        check("R10 mb_be half", {56'd0, f_be}, 64'h0C);
        check("R9 R10 masked data", rsp_rdata, 64'h0000_0000_4433_0000);
        access(1'b0, 12'h404, 2'd2, 64'd0);
        check("R2 narrow word fwd", {63'd0, f_valid}, 64'd1);
        check("R2 narrow word err", {63'd0, rsp_err}, 64'd0);
        check("R10 upper word data", rsp_rdata, 64'h8877_6655_0000_0000);
        access(1'b0, 12'h400, 2'd3, 64'd0);
        check("R2 narrow quad no fwd", {63'd0, f_valid}, 64'd0);
        check("R2 narrow quad err", {63'd0, rsp_err}, 64'd1);
        check("R2 narrow quad data", rsp_rdata, 64'd0);
        access(1'b1, 12'h410, 2'd3, 64'hDEAD_BEEF_0123_4567);
        check("R9 write fwd", {63'd0, f_valid}, 64'd1);
        check("R9 mb_write", {63'd0, f_write}, 64'd1);
        check("R9 mb_wdata", f_wdata, 64'hDEAD_BEEF_0123_4567);
        check("R9 write addr", {52'd0, f_addr}, 64'h10);
        access(1'b1, 12'h40C, 2'd3, 64'h1);
        check("R1 misaligned write no fwd", {63'd0, f_valid}, 64'd0);
        check("R1 misaligned write err", {63'd0, rsp_err}, 64'd1);

        // writes to read-only areas
        access(1'b1, 12'h000, 2'd3, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R8 caps write err", {63'd0, rsp_err}, 64'd0);
        check("R8 caps write no fwd", {63'd0, f_valid}, 64'd0);
        access(1'b0, 12'h000, 2'd3, 64'd0);
        check("R8 header unchanged", rsp_rdata, 64'h0000_0003_0001_0000);
        access(1'b1, 12'h800, 2'd3, 64'd0);
        check("R8 memdev write no fwd", {63'd0, f_valid}, 64'd0);
        access(1'b0, 12'h800, 2'd3, 64'd0);
        check("R8 memdev unchanged", rsp_rdata, 64'h6);
        access(1'b1, 12'h108, 2'd3, 64'h55);
        access(1'b0, 12'h108, 2'd3, 64'd0);
        check("R8 devst unchanged", rsp_rdata, 64'd0);
        access(1'b1, 12'hA00, 2'd3, 64'h77);
        check("R11 hole write err", {63'd0, rsp_err}, 64'd0);
        access(1'b0, 12'hA00, 2'd3, 64'd0);
        check("R11 hole read", rsp_rdata, 64'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule